// File: doc/BRIEF.md
# Constant-on-time switching sequencer

This block is the digital timing core of a synchronous step-down controller that uses constant on-time control. It has no clock-derived switching period. A high-side conduction pulse is launched only when three conditions hold at once: the error comparator asks for more energy, the valley current sensed through the low-side switch is under the current limit, and a minimum off-time has run out since the last high-side pulse ended. The width of each high-side pulse comes from an on-time count. That count is produced upstream by an input-voltage feed-forward calculation and is proportional to VOUT/VIN. The block applies a minimum on-time floor to it and latches it at the start of the pulse.

Between the two gate enables the block inserts break-before-make dead time in both directions. In automatic mode, low-side conduction ends when the inductor current crosses zero, and the converter drops into pulse-frequency operation at light load. In forced-PWM mode the zero crossing is ignored and the low side conducts until the next high-side pulse. All three comparator flags pass through a two-flop synchroniser. A global gate-off input drops both enables in the same cycle. After gate-off is released, the next pulse waits for the full minimum off-time and dead time.

Top module: `cot_sequencer`

## Requirements
- R1: Under reset both gate enables are low. With demand present from reset release, the first high-side pulse starts exactly MIN_OFF+DEAD+1 cycles after the first non-reset clock edge.
- R2: A new high-side pulse begins only when the synchronised error flag is high, the synchronised valley-current flag is low and the minimum off-time has expired. While the error flag stays low, no pulse starts.
- R3: Each high-side pulse lasts max(ton_cycles, MIN_ON) cycles. ton_cycles is sampled when the pulse starts, so a later change affects only the next pulse.
- R4: After a high-side pulse ends, the high side stays low for at least MIN_OFF cycles. Under continuous demand it stays low for exactly MIN_OFF+DEAD+1 cycles.
- R5: Both gap directions last exactly DEAD cycles with both enables low: high-side falling to low-side rising, and low-side falling to high-side rising. The two enables are never high together.
- R6: In automatic mode (fpwm_mode=0), a zero-cross flag during low-side conduction drops the low side within three cycles. Both enables then stay low until the next pulse starts.
- R7: In forced-PWM mode (fpwm_mode=1), the zero-cross flag has no effect, and the low side keeps conducting until the next high-side pulse.
- R8: While gate_off is high, both enables are low, starting in the same cycle it is asserted.
- R9: After gate_off is released with demand present, the first high-side pulse starts exactly MIN_OFF+DEAD+1 cycles later, and the low side stays low until then.
- R10: While the valley-current flag is high, no high-side pulse starts. In forced-PWM mode the low side stays on through that interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_off | input | 1 | Global disable, forces both enables low at once |
| fpwm_mode | input | 1 | 1 = forced PWM, 0 = automatic PFM/PWM |
| err_hi_a | input | 1 | Error comparator high (asynchronous) |
| ilim_a | input | 1 | Valley current above limit (asynchronous) |
| zc_a | input | 1 | Inductor current zero crossing (asynchronous) |
| ton_cycles | input | TON_W | High-side on-time in clock cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bound checker watches the following on every cycle:
- the two enables never overlap;
- each gap is at least DEAD cycles;
- each high-side pulse meets the minimum on-time, and the minimum off-time holds before every rising edge;
- every launch was preceded by a clear current flag and a high error flag;
- a zero crossing in automatic mode ends low-side conduction;
- forced-PWM conduction persists;
- gate-off sends the sequencer to its idle state.

Only the directed scenarios can show the exact pulse widths chosen from ton_cycles, and the latching of ton_cycles at pulse start. The same holds for the exact restart latency after reset and after gate-off release, and for the absence of any launch over long stretches with the current flag set or the error flag low.

// File: rtl/cot_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the constant-on-time sequencer.
// Assumes: nothing; pure type definitions.
package cot_seq_pkg;

    // Switching phase; exactly one gate may be enabled per phase.
    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,  // both off, waiting for a start request
        PH_DEAD_LH = 3'd1,  // low side released, high side not yet on
        PH_HIGH    = 3'd2,  // high-side conduction (on-time one-shot)
        PH_DEAD_HL = 3'd3,  // high side released, low side not yet on
        PH_LOW     = 3'd4   // low-side conduction
    } phase_e;

endpackage

// File: rtl/cot_sync.sv
`timescale 1ns/1ps
// Multi-bit flop-chain synchroniser for independent asynchronous flags.
// Assumes: each bit is a level that is stable for several clocks, so
// no bit-to-bit coherence is needed; STAGES >= 2.
module cot_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous flags through the resynchronising stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cot_oneshot.sv
`timescale 1ns/1ps
// Loadable down-counting one-shot; done is high while the count is zero.
// Assumes: load has priority over counting; the count parks at zero.
module cot_oneshot #(
    parameter int W       = 10,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/cot_sequencer.sv
`timescale 1ns/1ps
// Constant-on-time switching sequencer for a synchronous buck stage.
// Launches a high-side pulse when demand is present, the valley current
// is under limit and the minimum off-time has expired. Inserts dead time
// in both directions. In automatic mode it truncates low-side conduction
// at the inductor zero crossing.
// Assumes: comparator flags are asynchronous levels; ton_cycles is
// already scaled to clock cycles; 1 <= DEAD <= MIN_OFF; MIN_ON >= 1;
// MIN_ON and DEAD fit in TON_W bits.
module cot_sequencer
    import cot_seq_pkg::*;
#(
    parameter int TON_W   = 10,
    parameter int MIN_ON  = 28,
    parameter int MIN_OFF = 113,
    parameter int DEAD    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_off,
    input  logic             fpwm_mode,
    input  logic             err_hi_a,
    input  logic             ilim_a,
    input  logic             zc_a,
    input  logic [TON_W-1:0] ton_cycles,
    output logic             hs_en,
    output logic             ls_en
);

    localparam int             PH_W     = TON_W;
    localparam int             OFF_W    = $clog2(MIN_OFF + 1);
    localparam logic [PH_W-1:0] MIN_ON_V = PH_W'(MIN_ON);
    localparam logic [PH_W-1:0] DEAD_LD  = PH_W'(DEAD - 1);
    localparam logic [OFF_W-1:0] OFF_LD  = OFF_W'(MIN_OFF);

    phase_e           state_q, state_d;
    logic             err_s, ilim_s, zc_s;
    logic             ph_load, ph_done;
    logic [PH_W-1:0]  ph_val;
    logic [PH_W-1:0]  ton_eff;
    logic             off_load, off_done;
    logic             start_ok;

    // Resynchronise the three comparator flags.
    cot_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({err_hi_a, ilim_a, zc_a}),
        .q_sync  ({err_s, ilim_s, zc_s})
    );

    // Phase timer: times the high-side pulse and both dead gaps.
    cot_oneshot #(.W(PH_W), .RST_VAL(0)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    // Off timer: minimum off-time measured from the high-side turn-off.
    cot_oneshot #(.W(OFF_W), .RST_VAL(MIN_OFF)) u_off_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (off_load),
        .load_val (OFF_LD),
        .done     (off_done)
    );

    // Apply the minimum on-time floor to the requested on-time.
    always_comb begin
        ton_eff = (ton_cycles < MIN_ON_V) ? MIN_ON_V : ton_cycles;
    end

    assign start_ok = err_s & ~ilim_s & off_done;

    // Next-phase and timer-load decisions.
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = DEAD_LD;
        off_load = 1'b0;
        if (gate_off) begin
            state_d  = PH_OFF;
            off_load = 1'b1;
        end else begin
            case (state_q)
                PH_OFF: begin
                    if (start_ok) begin
                        state_d = PH_DEAD_LH;
                        ph_load = 1'b1;
                    end
                end
                PH_DEAD_LH: begin
                    if (ph_done) begin
                        state_d = PH_HIGH;
                        ph_load = 1'b1;
                        ph_val  = ton_eff - PH_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (ph_done) begin
                        state_d  = PH_DEAD_HL;
                        ph_load  = 1'b1;
                        off_load = 1'b1;
                    end
                end
                PH_DEAD_HL: begin
                    if (ph_done) begin
                        state_d = PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (start_ok) begin
                        state_d = PH_DEAD_LH;
                        ph_load = 1'b1;
                    end else if (!fpwm_mode && zc_s) begin
                        state_d = PH_OFF;
                    end
                end
                default: state_d = PH_OFF;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Gate enables; gate_off masks them without waiting for a clock edge.
    assign hs_en = (state_q == PH_HIGH) & ~gate_off;
    assign ls_en = (state_q == PH_LOW)  & ~gate_off;

endmodule

// File: rtl/cot_sequencer_chk.sv
`timescale 1ns/1ps
// Protocol checker for cot_sequencer, attached with bind.
// Assumes: parameters match the bound instance; counters saturate at 16 bits.
module cot_sequencer_chk
    import cot_seq_pkg::*;
#(
    parameter int MIN_ON  = 28,
    parameter int MIN_OFF = 113,
    parameter int DEAD    = 5
) (
    input logic   clk,
    input logic   rst_n,
    input logic   gate_off,
    input logic   fpwm_mode,
    input logic   err_s,
    input logic   ilim_s,
    input logic   zc_s,
    input phase_e state_q,
    input logic   hs_en,
    input logic   ls_en
);

    logic [15:0] hs_on_cnt, hs_off_cnt, ls_off_cnt;

    // Run lengths of high and low levels on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_on_cnt  <= '0;
            hs_off_cnt <= '0;
            ls_off_cnt <= '0;
        end else begin
            hs_on_cnt  <= !hs_en ? 16'd0 : (hs_on_cnt  == 16'hFFFF ? hs_on_cnt  : hs_on_cnt  + 16'd1);
            hs_off_cnt <=  hs_en ? 16'd0 : (hs_off_cnt == 16'hFFFF ? hs_off_cnt : hs_off_cnt + 16'd1);
            ls_off_cnt <=  ls_en ? 16'd0 : (ls_off_cnt == 16'hFFFF ? ls_off_cnt : ls_off_cnt + 16'd1);
        end
    end

    assert_gates_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    assert_dead_hs_to_ls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> (hs_off_cnt >= 16'(DEAD)));

    assert_dead_ls_to_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (ls_off_cnt >= 16'(DEAD)));

    assert_min_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_en) && !gate_off) |-> (hs_on_cnt >= 16'(MIN_ON)));

    assert_min_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (hs_off_cnt >= 16'(MIN_OFF)));

    assert_launch_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DEAD_LH && $past(state_q) != PH_DEAD_LH) |-> $past(!ilim_s && err_s));

    assert_zc_truncates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW && zc_s && !fpwm_mode) |=> !ls_en);

    assert_fpwm_holds_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && fpwm_mode && !err_s && !gate_off) |=> (ls_en || gate_off));

    assert_gate_off_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> (state_q == PH_OFF));

endmodule

bind cot_sequencer cot_sequencer_chk #(
    .MIN_ON  (MIN_ON),
    .MIN_OFF (MIN_OFF),
    .DEAD    (DEAD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_off  (gate_off),
    .fpwm_mode (fpwm_mode),
    .err_s     (err_s),
    .ilim_s    (ilim_s),
    .zc_s      (zc_s),
    .state_q   (state_q),
    .hs_en     (hs_en),
    .ls_en     (ls_en)
);

// File: tb/cot_sequencer_bench.sv
`timescale 1ns/1ps
// Directed bench for cot_sequencer: one task per scenario.
module cot_sequencer_bench;

    localparam int TON_W   = 10;
    localparam int MIN_ON  = 28;
    localparam int MIN_OFF = 113;
    localparam int DEAD    = 5;
    localparam int RESTART = MIN_OFF + DEAD + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gate_off = 1'b0;
    logic             fpwm_mode = 1'b1;
    logic             err_hi_a = 1'b0;
    logic             ilim_a = 1'b0;
    logic             zc_a = 1'b0;
    logic [TON_W-1:0] ton_cycles = 10'd60;
    logic             hs_en, ls_en;

    int n_tests = 0;
    int n_fail  = 0;

    // Monitor state, sampled on falling edges.
    int hs_rises = 0, overlap = 0, hi_run = 0, lo_run = 0;
    int last_hs_w = 0, last_hs_low = 0, gap = 0, dead_hl = 0, dead_lh = 0;
    bit hs_p = 0, ls_p = 0, src_hs = 0;

    always #2 clk = ~clk;

    cot_sequencer u_cot_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_off   (gate_off),
        .fpwm_mode  (fpwm_mode),
        .err_hi_a   (err_hi_a),
        .ilim_a     (ilim_a),
        .zc_a       (zc_a),
        .ton_cycles (ton_cycles),
        .hs_en      (hs_en),
        .ls_en      (ls_en)
    );

    // Measure pulse widths, low intervals and dead gaps.
    always @(negedge clk) begin
        if (!rst_n) begin
            hs_rises = 0; hi_run = 0; lo_run = 0; gap = 0;
            hs_p = 0; ls_p = 0; src_hs = 0;
        end else begin
            if (hs_en && ls_en) overlap++;
            if (hs_en) begin
                if (!hs_p) begin last_hs_low = lo_run; hs_rises++; hi_run = 1; end
                else hi_run++;
            end else begin
                if (hs_p) begin last_hs_w = hi_run; lo_run = 1; end
                else lo_run++;
            end
            if (!hs_en && !ls_en) begin
                if (hs_p) begin src_hs = 1; gap = 1; end
                else if (ls_p) begin src_hs = 0; gap = 1; end
                else gap++;
            end
            if (ls_en && !ls_p && src_hs) dead_hl = gap;
            if (hs_en && !hs_p && !src_hs) dead_lh = gap;
            hs_p = hs_en;
            ls_p = ls_en;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic at_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_rises(input int n, input string req);
        int target;
        target = hs_rises + n;
        for (int i = 0; i < 20000 && hs_rises < target; i++) @(negedge clk);
        check_eq({req, " pulse seen"}, int'(hs_rises >= target), 1);
    endtask

    task automatic t_reset();
        int n;
        n = 0;
        repeat (5) @(posedge clk);
        #2;
        check_eq("R1 hs low in reset", int'(hs_en), 0);
        check_eq("R1 ls low in reset", int'(ls_en), 0);
        err_hi_a = 1'b1;
        at_edge();
        rst_n = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (hs_en) break;
            n++;
        end
        check_eq("R1 first pulse latency", n, RESTART);
    endtask

    task automatic t_steady();
        wait_rises(3, "R3");
        check_eq("R3 on-time width", last_hs_w, 60);
        check_eq("R4 off interval", last_hs_low, RESTART);
        check_eq("R5 dead hs->ls", dead_hl, DEAD);
        check_eq("R5 dead ls->hs", dead_lh, DEAD);
    endtask

    task automatic t_min_on();
        at_edge(); ton_cycles = 10'd3;
        wait_rises(3, "R3");
        check_eq("R3 floor for short on-time", last_hs_w, MIN_ON);
        at_edge(); ton_cycles = 10'd0;
        wait_rises(3, "R3");
        check_eq("R3 floor for zero on-time", last_hs_w, MIN_ON);
    endtask

    task automatic t_latch();
        at_edge(); ton_cycles = 10'd60;
        wait_rises(2, "R3");
        repeat (5) @(negedge clk);
        at_edge(); ton_cycles = 10'd40;
        wait_rises(1, "R3");
        check_eq("R3 on-time latched at start", last_hs_w, 60);
        wait_rises(1, "R3");
        check_eq("R3 new on-time next pulse", last_hs_w, 40);
    endtask

    task automatic t_ilim();
        int base;
        at_edge(); ilim_a = 1'b1;
        repeat (10) @(negedge clk);
        base = hs_rises;
        repeat (600) @(negedge clk);
        check_eq("R10 no launch under current limit", hs_rises, base);
        check_eq("R10 low side kept on", int'(ls_en), 1);
        at_edge(); ilim_a = 1'b0;
        wait_rises(1, "R2 resume after limit");
    endtask

    task automatic t_err_low();
        int base;
        at_edge(); err_hi_a = 1'b0;
        repeat (10) @(negedge clk);
        base = hs_rises;
        repeat (400) @(negedge clk);
        check_eq("R2 no launch without demand", hs_rises, base);
    endtask

    task automatic t_zc_fpwm();
        @(negedge clk);
        check_eq("R7 low side on before zero cross", int'(ls_en), 1);
        at_edge(); zc_a = 1'b1;
        repeat (20) @(negedge clk);
        check_eq("R7 zero cross ignored", int'(ls_en), 1);
        at_edge(); zc_a = 1'b0;
    endtask

    task automatic t_zc_auto();
        int highs;
        highs = 0;
        at_edge(); fpwm_mode = 1'b0; err_hi_a = 1'b1;
        wait_rises(1, "R6");
        at_edge(); err_hi_a = 1'b0;
        for (int i = 0; i < 2000 && !ls_en; i++) @(negedge clk);
        check_eq("R6 low side reached", int'(ls_en), 1);
        repeat (3) @(negedge clk);
        at_edge(); zc_a = 1'b1;
        repeat (3) at_edge();
        @(negedge clk);
        check_eq("R6 low side truncated", int'(ls_en), 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (hs_en || ls_en) highs++;
        end
        check_eq("R6 both off until next start", highs, 0);
        at_edge(); zc_a = 1'b0;
    endtask

    task automatic t_disable();
        int highs, n, lsh;
        highs = 0; n = 0; lsh = 0;
        at_edge(); fpwm_mode = 1'b1; err_hi_a = 1'b1;
        wait_rises(1, "R8");
        repeat (5) @(negedge clk);
        at_edge(); gate_off = 1'b1;
        @(negedge clk);
        check_eq("R8 same-cycle drop", int'(hs_en || ls_en), 0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (hs_en || ls_en) highs++;
        end
        check_eq("R8 held off", highs, 0);
        at_edge(); gate_off = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (hs_en) break;
            if (ls_en) lsh++;
            n++;
        end
        check_eq("R9 restart latency", n, RESTART);
        check_eq("R9 low side stays off", lsh, 0);
    endtask

    initial begin
        #600000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_steady();
        t_min_on();
        t_latch();
        t_ilim();
        t_err_low();
        t_zc_fpwm();
        t_zc_auto();
        t_disable();
        check_eq("R5 no overlap", overlap, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule